// File: doc/BRIEF.md
# Infrared Front-End Mode Controller

This block is a cycle-based digital model of the control logic that sits between a host's infrared encoder/decoder and an optical front end. Its two control inputs are a shutdown strobe and the transmit data line. From them it works out the power state, holds a receive pulse-width setting, and gates the emitter drive. The optical path reports each detected light pulse as a one-cycle strobe. The block stretches that strobe into an active-low receive-data pulse. The pulse is either short or long, depending on the held setting.

The host picks the pulse width with a brief shutdown strobe. When the strobe falls, the transmit line is sampled. A high level picks the short width and a low level picks the long width, so with the transmit line idle a bare strobe gives the long width. A strobe held for the full shutdown time powers the block down. Leaving shutdown acts as a fresh start: the width returns to short and the receiver needs a start-up period before it is ready again. A transmit watchdog cuts the emitter when the transmit line stays high too long. Every time constant is a parameter in clock cycles.

Top module: `ir_mode_ctrl`

## Requirements
- R1: While reset is active and just after it, `rxd_out` is 1, `rxd_oe` is 1, `rx_ready` is 0 and `led_en` is 0.
- R2: After reset the width setting is short. An accepted optical strobe drives `rxd_out` low for exactly SHORT_CYC cycles.
- R3: When `sd_in` falls after being high for 1 to PROG_CYC-1 cycles, the width setting is loaded from `txd_in` at that edge: 1 gives short, 0 gives long.
- R4: With the long setting, an accepted optical strobe drives `rxd_out` low for exactly LONG_CYC cycles.
- R5: When `sd_in` is high for SHDN_CYC cycles or more, the block enters shutdown. When `sd_in` then falls, the width setting becomes short whatever the level of `txd_in`.
- R6: In shutdown, `rxd_oe` is 0, `rx_ready` is 0, `rxd_out` is 1 and `led_en` is 0.
- R7: `led_en` goes to 0 once `txd_in` has been high for TXG_CYC consecutive cycles.
- R8: `rx_ready` stays 0 for STUP_CYC cycles after reset and after leaving shutdown. An optical strobe that arrives while `rx_ready` is 0 has no effect on `rxd_out`.
- R9: `led_en` is 1 only while `txd_in` is 1 and `sd_in` is 0.
- R10: A strobe that arrives while a receive pulse is still active reloads the full width from that cycle. One longer low pulse results, not two pulses.
- R11: An `sd_in` high time from PROG_CYC to SHDN_CYC-1 cycles leaves the width setting unchanged and does not cause shutdown.
- R12: Once the watchdog has cut the emitter, it re-enables only after `txd_in` has returned to 0. The next rising edge of `txd_in` drives the emitter again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_in | input | 1 | Shutdown and programming strobe, active high |
| txd_in | input | 1 | Transmit data; also the width selector during programming |
| opt_pulse | input | 1 | One-cycle strobe for a detected optical pulse |
| led_en | output | 1 | Emitter drive enable |
| rxd_out | output | 1 | Receive data, active low |
| rxd_oe | output | 1 | Receive data output enable, low in shutdown |
| rx_ready | output | 1 | Receiver has finished its start-up time |

## Verification
Some properties are checked on every cycle. The emitter is gated by the shutdown strobe and the transmit line. A counter in the checker bounds how long the emitter can stay on under a continuous transmit high. The receive output is quiet and released in shutdown. A receive pulse can only begin right after an accepted strobe while the receiver is ready.

Other behaviours need the bench's scenarios. These are the exact pulse widths, the retrigger length, the width setting each kind of strobe leaves behind (short, middle or shutdown length), the return to the short width after shutdown, and the watchdog releasing only after the transmit line goes low. A scoreboard compares each receive pulse width against the value predicted when its strobe was driven.

// File: rtl/ir_mode_pkg.sv
package ir_mode_pkg;
  typedef enum logic {
    PW_SHORT = 1'b0,
    PW_LONG  = 1'b1
  } pw_mode_e;
endpackage

// File: rtl/ir_sd_monitor.sv
// Measures the shutdown strobe high time and decides programming versus shutdown.
module ir_sd_monitor
  import ir_mode_pkg::*;
#(
  parameter int PROG_CYC = 30000,
  parameter int SHDN_CYC = 75000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sd_in,
  input  logic     txd_in,
  output logic     shdn,
  output logic     wake,
  output pw_mode_e mode
);
  localparam int W = $clog2(SHDN_CYC + 1);
  localparam logic [W-1:0] PROG_LIM = W'(PROG_CYC);
  localparam logic [W-1:0] SHDN_LIM = W'(SHDN_CYC);
  localparam logic [W-1:0] SHDN_PRE = W'(SHDN_CYC - 1);

  logic [W-1:0] hi_cnt_q, hi_cnt_d;
  logic         cnt_en;
  logic         shdn_q, shdn_d;
  pw_mode_e     mode_q, mode_d;
  logic         mode_en;
  logic         sd_fall, prog_fall;

  always_comb begin
    sd_fall   = !sd_in && (hi_cnt_q != '0);
    cnt_en    = sd_in ? (hi_cnt_q != SHDN_LIM) : sd_fall;
    hi_cnt_d  = sd_in ? hi_cnt_q + 1'b1 : '0;
    shdn_d    = sd_in && (shdn_q || (hi_cnt_q == SHDN_PRE));
    wake      = sd_fall && shdn_q;
    prog_fall = sd_fall && (hi_cnt_q < PROG_LIM);
    mode_en   = wake || prog_fall;
    mode_d    = mode_q;
    if (wake)           mode_d = PW_SHORT;
    else if (prog_fall) mode_d = txd_in ? PW_SHORT : PW_LONG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q <= '0;
      shdn_q   <= 1'b0;
      mode_q   <= PW_SHORT;
    end else begin
      if (cnt_en)  hi_cnt_q <= hi_cnt_d;
      shdn_q <= shdn_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  assign shdn = shdn_q;
  assign mode = mode_q;
endmodule

// File: rtl/ir_startup.sv
// Receiver start-up timer, restarted by reset and by leaving shutdown.
module ir_startup #(
  parameter int STUP_CYC = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  input  logic shdn,
  output logic rx_ready
);
  localparam int W = $clog2(STUP_CYC + 1);
  localparam logic [W-1:0] LIM = W'(STUP_CYC);

  logic [W-1:0] su_q, su_d;
  logic         su_en;

  always_comb begin
    su_en = wake || (su_q != LIM);
    su_d  = wake ? '0 : su_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     su_q <= '0;
    else if (su_en) su_q <= su_d;
  end

  assign rx_ready = (su_q == LIM) && !shdn;
endmodule

// File: rtl/ir_tx_guard.sv
// Emitter gating with a watchdog on continuous transmit-high time.
module ir_tx_guard #(
  parameter int TXG_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sd_in,
  input  logic txd_in,
  output logic led_en
);
  localparam int W = $clog2(TXG_CYC + 1);
  localparam logic [W-1:0] LIM = W'(TXG_CYC);
  localparam logic [W-1:0] PRE = W'(TXG_CYC - 1);

  logic [W-1:0] run_q, run_d;
  logic         run_en;
  logic         trip_q, trip_d;

  always_comb begin
    run_en = txd_in ? (run_q != LIM) : (run_q != '0);
    run_d  = txd_in ? run_q + 1'b1 : '0;
    trip_d = txd_in && (trip_q || (run_q == PRE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      if (run_en) run_q <= run_d;
      trip_q <= trip_d;
    end
  end

  assign led_en = txd_in && !sd_in && !trip_q;
endmodule

// File: rtl/ir_rx_stretch.sv
// Stretches a one-cycle optical strobe to the selected receive pulse width.
module ir_rx_stretch
  import ir_mode_pkg::*;
#(
  parameter int SHORT_CYC = 20,
  parameter int LONG_CYC  = 100
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     opt_pulse,
  input  logic     rx_ready,
  input  pw_mode_e mode,
  output logic     rx_active
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int W = $clog2(MAXC + 1);
  localparam logic [W-1:0] SHORT_LIM = W'(SHORT_CYC);
  localparam logic [W-1:0] LONG_LIM  = W'(LONG_CYC);

  logic [W-1:0] st_q, st_d;
  logic         st_en, start;

  always_comb begin
    start = opt_pulse && rx_ready;
    st_en = !rx_ready || start || (st_q != '0);
    if (!rx_ready)  st_d = '0;
    else if (start) st_d = (mode == PW_LONG) ? LONG_LIM : SHORT_LIM;
    else            st_d = st_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign rx_active = (st_q != '0);
endmodule

// File: rtl/ir_mode_ctrl.sv
module ir_mode_ctrl
  import ir_mode_pkg::*;
#(
  parameter int SHORT_CYC = 20,
  parameter int LONG_CYC  = 100,
  parameter int TXG_CYC   = 4000,
  parameter int PROG_CYC  = 30000,
  parameter int SHDN_CYC  = 75000,
  parameter int STUP_CYC  = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sd_in,
  input  logic txd_in,
  input  logic opt_pulse,
  output logic led_en,
  output logic rxd_out,
  output logic rxd_oe,
  output logic rx_ready
);
  logic     rst_meta_q, core_rst_n;
  logic     shdn, wake, rx_active;
  pw_mode_e mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      core_rst_n <= rst_meta_q;
    end
  end

  ir_sd_monitor #(.PROG_CYC(PROG_CYC), .SHDN_CYC(SHDN_CYC)) u_sd (
    .clk(clk), .rst_n(core_rst_n), .sd_in(sd_in), .txd_in(txd_in),
    .shdn(shdn), .wake(wake), .mode(mode)
  );

  ir_startup #(.STUP_CYC(STUP_CYC)) u_su (
    .clk(clk), .rst_n(core_rst_n), .wake(wake), .shdn(shdn),
    .rx_ready(rx_ready)
  );

  ir_tx_guard #(.TXG_CYC(TXG_CYC)) u_tx (
    .clk(clk), .rst_n(core_rst_n), .sd_in(sd_in), .txd_in(txd_in),
    .led_en(led_en)
  );

  ir_rx_stretch #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_rx (
    .clk(clk), .rst_n(core_rst_n), .opt_pulse(opt_pulse),
    .rx_ready(rx_ready), .mode(mode), .rx_active(rx_active)
  );

  assign rxd_out = !rx_active;
  assign rxd_oe  = !shdn;
endmodule

// File: rtl/ir_mode_ctrl_chk.sv
module ir_mode_ctrl_chk #(
  parameter int TXG_CYC = 4000
) (
  input logic clk,
  input logic rst_n,
  input logic sd_in,
  input logic txd_in,
  input logic opt_pulse,
  input logic led_en,
  input logic rxd_out,
  input logic rxd_oe,
  input logic rx_ready
);
  localparam int W = $clog2(TXG_CYC + 1);
  localparam logic [W-1:0] LIM = W'(TXG_CYC);

  logic [W-1:0] tx_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tx_run <= '0;
    else if (!txd_in)              tx_run <= '0;
    else if (tx_run != LIM)        tx_run <= tx_run + 1'b1;
  end

  AST_LED_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    led_en |-> (txd_in && !sd_in));                                   // R9
  AST_TX_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
    led_en |-> (tx_run < LIM));                                       // R7
  AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rxd_oe |-> (!rx_ready && rxd_out && !led_en));                   // R6
  AST_OE_DROP_SD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxd_oe) |-> $past(sd_in));                                  // R5
  AST_PULSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxd_out) |-> ($past(opt_pulse) && $past(rx_ready)));        // R8
  AST_READY_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> rxd_oe);                                      // R8
endmodule

bind ir_mode_ctrl ir_mode_ctrl_chk #(.TXG_CYC(TXG_CYC)) u_chk (
  .clk(clk), .rst_n(core_rst_n), .sd_in(sd_in), .txd_in(txd_in),
  .opt_pulse(opt_pulse), .led_en(led_en), .rxd_out(rxd_out),
  .rxd_oe(rxd_oe), .rx_ready(rx_ready)
);

// File: tb/ir_mode_ctrl_test.sv
`timescale 1ns/1ps
module ir_mode_ctrl_test;
  localparam int SHORT_CYC = 4;
  localparam int LONG_CYC  = 12;
  localparam int TXG_CYC   = 40;
  localparam int PROG_CYC  = 60;
  localparam int SHDN_CYC  = 150;
  localparam int STUP_CYC  = 30;

  logic clk = 1'b0;
  logic rst_n, sd_in, txd_in, opt_pulse;
  logic led_en, rxd_out, rxd_oe, rx_ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ir_mode_ctrl #(
    .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .TXG_CYC(TXG_CYC),
    .PROG_CYC(PROG_CYC), .SHDN_CYC(SHDN_CYC), .STUP_CYC(STUP_CYC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sd_in(sd_in), .txd_in(txd_in),
    .opt_pulse(opt_pulse), .led_en(led_en), .rxd_out(rxd_out),
    .rxd_oe(rxd_oe), .rx_ready(rx_ready)
  );

  task automatic check_val(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #4;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  // driver: one-cycle optical strobe, expected width pushed to the scoreboard
  task automatic pulse(int exp_w, string tag);
    opt_pulse = 1'b1;
    step(1);
    opt_pulse = 1'b0;
    if (exp_w > 0) begin
      exp_q.push_back(exp_w);
      tag_q.push_back(tag);
    end
  endtask

  task automatic sd_strobe(int n, logic tx);
    txd_in = tx;
    step(1);
    sd_in = 1'b1;
    step(n);
    sd_in = 1'b0;
    step(1);
    txd_in = 1'b0;
  endtask

  // monitor: measures each low pulse on rxd_out and pops the expectation
  int width = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!rxd_out) width++;
      else if (width > 0) begin
        if (exp_q.size() == 0) begin
          n_chk++;
          n_fail++;
          $display("FAIL R8: actual pulse width %0d expected no pulse", width);
        end else begin
          string t;
          int e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check_val(t, width, e);
        end
        width = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sd_in = 1'b0; txd_in = 1'b0; opt_pulse = 1'b0;
    step(3);
    at_neg();
    check_val("R1", rxd_out, 1);
    check_val("R1", rxd_oe, 1);
    check_val("R1", rx_ready, 0);
    check_val("R1", led_en, 0);
    step(1);
    rst_n = 1'b1;
    step(5);
    pulse(0, "R8");                    // ignored during start-up
    at_neg();
    check_val("R8", rx_ready, 0);
    step(2);
    at_neg();
    check_val("R8", rxd_out, 1);
    step(35);
    at_neg();
    check_val("R8", rx_ready, 1);

    pulse(SHORT_CYC, "R2");
    step(15);

    sd_strobe(10, 1'b0);               // bare short strobe: long width
    step(3);
    pulse(LONG_CYC, "R4");
    step(20);

    pulse(0, "R10");                   // retrigger 5 cycles apart
    step(4);
    pulse(5 + LONG_CYC, "R10");
    step(30);

    sd_strobe(10, 1'b1);               // TXD high at the edge: short width
    step(3);
    pulse(SHORT_CYC, "R3");
    step(15);

    sd_strobe(10, 1'b0);
    step(3);
    sd_strobe(100, 1'b1);              // middle length: no change
    at_neg();
    check_val("R11", rxd_oe, 1);
    check_val("R11", rx_ready, 1);
    step(2);
    pulse(LONG_CYC, "R11");
    step(20);

    sd_in = 1'b1;                      // full shutdown
    step(200);
    at_neg();
    check_val("R6", rxd_oe, 0);
    check_val("R6", rx_ready, 0);
    check_val("R6", rxd_out, 1);
    txd_in = 1'b1;
    at_neg();
    check_val("R6", led_en, 0);
    step(1);
    txd_in = 1'b0;                     // low TXD at the edge would select long
    step(2);
    sd_in = 1'b0;
    step(2);
    at_neg();
    check_val("R5", rxd_oe, 1);
    check_val("R8", rx_ready, 0);
    step(3);
    pulse(0, "R8");
    step(40);
    at_neg();
    check_val("R8", rx_ready, 1);
    pulse(SHORT_CYC, "R5");
    step(15);

    txd_in = 1'b1;                     // emitter gating by SD
    at_neg();
    check_val("R9", led_en, 1);
    step(1);
    sd_in = 1'b1;
    at_neg();
    check_val("R9", led_en, 0);
    step(1);
    sd_in = 1'b0;
    at_neg();
    check_val("R9", led_en, 1);
    step(1);
    txd_in = 1'b0;
    step(3);

    txd_in = 1'b1;                     // watchdog
    step(10);
    at_neg();
    check_val("R7", led_en, 1);
    step(35);
    at_neg();
    check_val("R7", led_en, 0);
    step(20);
    at_neg();
    check_val("R12", led_en, 0);
    txd_in = 1'b0;
    step(3);
    at_neg();
    check_val("R12", led_en, 0);
    step(1);
    txd_in = 1'b1;
    at_neg();
    check_val("R12", led_en, 1);
    step(3);
    txd_in = 1'b0;
    step(5);

    check_val("R10", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule